// File: doc/BRIEF.md
# ECC Error Log Register Unit

This block records memory ECC events so that software can find and service them. Two event classes arrive as single-cycle pulses: correctable events, which carry a 34-bit address and a 16-bit syndrome, and uncorrectable events, which carry a 34-bit address. For each class the block keeps a first-error status bit and a next-error status bit. When the first event of a class arrives, the block captures its 4 KiB page address, and for the correctable class also its syndrome. That capture stays locked until software has cleared the status.

Software reaches the state through a plain byte-addressed register port. Writes take effect on the clock edge. Reads are combinational and show the state as of the last edge. Status bits clear when software writes one to them. The block also turns the captured syndrome into a failing channel index on a dedicated output.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `ce_chan` is 0.
- R2: An event of a class whose first-error and next-error bits are both clear sets that class's first-error bit and loads its log. The first-error status is at offset 0x80, with bit 0 for correctable and bit 1 for uncorrectable. The correctable address log is at 0xA0 and the uncorrectable address log is at 0xB0. Each address log reads address bits 33:12 in bits 27:6, with bits 31:28 and 5:0 zero. The correctable syndrome reads in bits 15:0 at 0xD0.
- R3: An event of a class whose first-error bit is already set sets that class's next-error bit at offset 0x82 (same bit layout as 0x80) and leaves the logs unchanged.
- R4: Writing to 0x80 or 0x82 clears each of bits 1:0 that is written as one. Bits written as zero keep their value.
- R5: An event arriving in the same cycle as a write-one clear of its first-error bit wins: that first-error bit stays set.
- R6: While a class's next-error bit is set, an event of that class sets the first-error bit but does not load the log. Loading resumes once both bits of the class are clear.
- R7: Writes to log registers or unmapped offsets change nothing. Reads of unmapped offsets return zero.
- R8: `ce_chan` is decoded from the captured syndrome. It is 0 when syndrome bits 15:8 are zero. Otherwise it is 1 when bits 7:0 are zero. Otherwise it is 0 when bits 15:12 or bits 11:8 are zero. In every other case it is 1.
- R9: The two classes are independent. Correctable and uncorrectable events in the same cycle are each recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable event pulse |
| ce_addr | input | 34 | Correctable event address |
| ce_syn | input | 16 | Correctable event syndrome |
| ue_evt | input | 1 | Uncorrectable event pulse |
| ue_addr | input | 34 | Uncorrectable event address |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| ce_chan | output | 1 | Failing channel decoded from the syndrome log |

## Verification
The bench targets several collisions:
- **Event during a clear of the same bit.** A design that lets the clear win would drop the error entirely.
- **Clearing only the first-error bit while next-error is still set.** A design that unlocks too early would overwrite the log with a later address.
- **Second event of a class.** A design that reloads the logs would lose the first address and syndrome.
- **Writes to log and unmapped offsets.** These would corrupt captured data.

It also feeds syndromes that take every branch of the channel decode. It drives both classes in the same cycle to expose cross-class interference.

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int AW        = 34,
  parameter int SW        = 16,
  parameter int RAW       = 8,
  parameter int DW        = 32,
  parameter int PG_SHIFT  = 12,
  parameter int LOG_SHIFT = 6,
  parameter logic [RAW-1:0] OFF_FIRST = 8'h80,
  parameter logic [RAW-1:0] OFF_NEXT  = 8'h82,
  parameter logic [RAW-1:0] OFF_CLOG  = 8'hA0,
  parameter logic [RAW-1:0] OFF_ULOG  = 8'hB0,
  parameter logic [RAW-1:0] OFF_SYN   = 8'hD0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ce_evt,
  input  logic [AW-1:0]  ce_addr,
  input  logic [SW-1:0]  ce_syn,
  input  logic           ue_evt,
  input  logic [AW-1:0]  ue_addr,
  input  logic [RAW-1:0] reg_addr,
  input  logic           reg_we,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           ce_chan
);
  localparam int PW  = AW - PG_SHIFT;
  localparam int TOP = DW - PW - LOG_SHIFT;
  localparam int HB  = SW / 2;
  localparam int QB  = SW / 4;

  logic [1:0]    first_q, next_q;
  logic [PW-1:0] ce_log, ue_log;
  logic [SW-1:0] syn_q;

  wire [1:0] evt       = {ue_evt, ce_evt};
  wire [1:0] clr_first = (reg_we && reg_addr == OFF_FIRST) ? reg_wdata[1:0] : 2'b00;
  wire [1:0] clr_next  = (reg_we && reg_addr == OFF_NEXT)  ? reg_wdata[1:0] : 2'b00;
  wire [1:0] load      = evt & ~first_q & ~next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= '0;
      next_q  <= '0;
      ce_log  <= '0;
      ue_log  <= '0;
      syn_q   <= '0;
    end else begin
      first_q <= evt | (first_q & ~clr_first);
      next_q  <= (evt & first_q) | (next_q & ~clr_next);
      if (load[0]) begin
        ce_log <= ce_addr[AW-1:PG_SHIFT];
        syn_q  <= ce_syn;
      end
      if (load[1]) ue_log <= ue_addr[AW-1:PG_SHIFT];
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFF_FIRST: reg_rdata = {{(DW-2){1'b0}}, first_q};
      OFF_NEXT:  reg_rdata = {{(DW-2){1'b0}}, next_q};
      OFF_CLOG:  reg_rdata = {{TOP{1'b0}}, ce_log, {LOG_SHIFT{1'b0}}};
      OFF_ULOG:  reg_rdata = {{TOP{1'b0}}, ue_log, {LOG_SHIFT{1'b0}}};
      OFF_SYN:   reg_rdata = {{(DW-SW){1'b0}}, syn_q};
      default:   reg_rdata = '0;
    endcase
  end

  wire hi_zero = ~|syn_q[SW-1:HB];
  wire lo_zero = ~|syn_q[HB-1:0];
  wire q3_zero = ~|syn_q[SW-1:SW-QB];
  wire q2_zero = ~|syn_q[SW-QB-1:HB];

  assign ce_chan = hi_zero ? 1'b0 :
                   lo_zero ? 1'b1 :
                   (q3_zero || q2_zero) ? 1'b0 : 1'b1;
endmodule

module ecc_err_log_chk #(
  parameter int PW  = 22,
  parameter int SW  = 16,
  parameter int RAW = 8,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ce_evt,
  input logic           ue_evt,
  input logic           reg_we,
  input logic [RAW-1:0] reg_addr,
  input logic [DW-1:0]  reg_wdata,
  input logic [1:0]     first_q,
  input logic [1:0]     next_q,
  input logic [PW-1:0]  ce_log,
  input logic [PW-1:0]  ue_log,
  input logic [SW-1:0]  syn_q
);
  AST_CE_FIRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> first_q[0]); // R2
  AST_UE_FIRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt |=> first_q[1]); // R9
  AST_CE_NEXT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && first_q[0] |=> next_q[0]); // R3
  AST_CE_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && first_q[0] |=> $stable(ce_log) && $stable(syn_q)); // R3
  AST_UE_LOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ue_evt && first_q[1] |=> $stable(ue_log)); // R3
  AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h80 && reg_wdata[0] && !ce_evt |=> !first_q[0]); // R4
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 8'h80 && reg_wdata[1] && ue_evt |=> first_q[1]); // R5
  AST_LOCK_BY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt && next_q[0] |=> $stable(ce_log)); // R6
endmodule

bind ecc_err_log ecc_err_log_chk #(.PW(PW), .SW(SW), .RAW(RAW), .DW(DW)) i_chk (.*);

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;
  logic        clk = 0, rst_n = 0;
  logic        ce_evt = 0, ue_evt = 0, reg_we = 0;
  logic [33:0] ce_addr = 0, ue_addr = 0;
  logic [15:0] ce_syn = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        ce_chan;
  logic        rd_req = 0, rd_chan = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [31:0] exp; bit is_chan; string req; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  ecc_err_log i_ecc_err_log (.*);

  function automatic logic [31:0] fmt(input logic [33:0] a);
    return {4'b0, a[33:12], 6'b0};
  endfunction

  task automatic step();
    @(posedge clk); #1;
    ce_evt = 0; ue_evt = 0; reg_we = 0; rd_req = 0; rd_chan = 0;
  endtask

  task automatic ce(input logic [33:0] a, input logic [15:0] s);
    step(); ce_evt = 1; ce_addr = a; ce_syn = s;
  endtask

  task automatic ue(input logic [33:0] a);
    step(); ue_evt = 1; ue_addr = a;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(); reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
    item_t it;
    step(); rd_req = 1; reg_addr = a;
    it.exp = e; it.is_chan = 0; it.req = r; q.push_back(it);
  endtask

  task automatic chan(input logic e, input string r);
    item_t it;
    step(); rd_req = 1; rd_chan = 1;
    it.exp = {31'b0, e}; it.is_chan = 1; it.req = r; q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_req && q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        act = it.is_chan ? {31'b0, ce_chan} : reg_rdata;
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%h actual=%h expected=%h", it.req, reg_addr, act, it.exp);
        end
      end
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [33:0] A1 = 34'h2_1234_5678;
  localparam logic [33:0] A2 = 34'h1_ABCD_E000;
  localparam logic [33:0] U1 = 34'h3_0F0F_1000;
  localparam logic [33:0] U2 = 34'h0_0000_3FFF;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(8'h80, 0, "R1"); rd(8'h82, 0, "R1"); rd(8'hA0, 0, "R1");
    rd(8'hB0, 0, "R1"); rd(8'hD0, 0, "R1"); chan(0, "R1");
    ce(A1, 16'h0034);
    rd(8'h80, 1, "R2"); rd(8'hA0, fmt(A1), "R2"); rd(8'hD0, 32'h34, "R2"); chan(0, "R8");
    ce(A2, 16'h3400);
    rd(8'h82, 1, "R3"); rd(8'hA0, fmt(A1), "R3"); rd(8'hD0, 32'h34, "R3");
    ue(U1);
    rd(8'h80, 3, "R9"); rd(8'hB0, fmt(U1), "R2");
    wr(8'hA0, 32'hFFFF_FFFF); wr(8'hC4, 32'h1);
    rd(8'hA0, fmt(A1), "R7"); rd(8'h90, 0, "R7"); rd(8'h80, 3, "R7");
    wr(8'h82, 32'h1); rd(8'h82, 0, "R4");
    wr(8'h80, 32'h0); rd(8'h80, 3, "R4");
    wr(8'h80, 32'h1); rd(8'h80, 2, "R4");
    ce(A2, 16'h3400);
    rd(8'hA0, fmt(A2), "R2"); chan(1, "R8");
    step(); reg_we = 1; reg_addr = 8'h80; reg_wdata = 32'h1;
    ce_evt = 1; ce_addr = A1; ce_syn = 16'h1203;
    rd(8'h80, 3, "R5"); rd(8'h82, 1, "R5"); rd(8'hA0, fmt(A2), "R5");
    wr(8'h80, 32'h1);
    ce(A1, 16'h1203);
    rd(8'h80, 3, "R6"); rd(8'hA0, fmt(A2), "R6"); rd(8'hD0, 32'h3400, "R6");
    wr(8'h82, 32'h3); wr(8'h80, 32'h3);
    rd(8'h80, 0, "R4"); rd(8'h82, 0, "R4");
    step(); ce_evt = 1; ce_addr = A1; ce_syn = 16'h1203; ue_evt = 1; ue_addr = U2;
    rd(8'h80, 3, "R9"); rd(8'hA0, fmt(A1), "R6"); rd(8'hB0, fmt(U2), "R9"); chan(1, "R8");
    wr(8'h80, 32'h1);
    ce(A2, 16'h1003);
    rd(8'hD0, 32'h1003, "R2"); chan(0, "R8");
    step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule